// File: doc/BRIEF.md
# Single-Pin Programmable PWM Level Channel

This block holds a 6-bit level code and turns it into a pulse-width modulated output with 64 slots per period. The code is set from one control pin, and a static mode input selects how that pin is read.

In edge mode, every rising edge of the pin adds one to the code, and the code wraps from 63 back to 0. A controller can therefore lower the code by one by sending 63 edges. In button mode, the pin carries one of three states: up, down or idle. A state must stay stable for a debounce interval before it is taken as a press. A press steps the code once in its direction. If the press is held, the code steps again after a long hold delay, and then keeps stepping at a short repeat interval. In button mode the code stops at 0 and at 63 instead of wrapping.

All timing is counted in debounce units. Each unit is a fixed number of pulses of the timebase tick input. A shutdown input clears the code, forces the output low and freezes every timer.

Top module: `pwm_level_channel`

## Requirements
- R1: While reset is active, and after it is released, `code_o` is 0 and `pwm_o` is low.
- R2: In edge mode (`mode_i`=0), each 0-to-1 change of `pin_i[0]` increases `code_o` by one on the next clock. The code wraps from 63 to 0, so 63 edges lower it by one.
- R3: In button mode (`mode_i`=1), the pin encodes the press state: `pin_i`=2'b01 is up, 2'b10 is down and 2'b00 is idle. 2'b11 (both buttons) is treated as down.
- R4: In button mode, an up press or repeat adds one to the code. At 63 the code stays at 63.
- R5: In button mode, a down press or repeat subtracts one from the code. At 0 the code stays at 0.
- R6: A button state counts as a press only after it has stayed unchanged through `DEB_UNITS` unit strobes. A state that changes earlier causes no step.
- R7: While a press is held, the first repeat step comes `HOLD_UNITS` unit strobes after the strobe that accepted the press. Each following step comes `REP_UNITS` strobes after the one before.
- R8: One unit strobe occurs for every `UNIT_TICKS` pulses of `tick_i`. Button steps happen only on a unit strobe.
- R9: Over any 64 consecutive cycles with `pwm_en_i` high and the code constant, `pwm_o` is high for exactly `code_o` cycles. Code 0 gives a constant low, and code 63 gives 63 high cycles out of 64.
- R10: While `sleep_i` is high, the code is 0, `pwm_o` is low, pin activity is ignored, and the debounce, repeat and tick-divider state is frozen. Counting resumes from that frozen state when `sleep_i` goes low.
- R11: Once the idle state has been debounced, no further steps occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| tick_i | input | 1 | Timebase tick pulse, one clock wide |
| pwm_en_i | input | 1 | Enable that advances the PWM slot counter |
| mode_i | input | 1 | 0 = edge mode, 1 = button mode |
| pin_i | input | 2 | Control pin state: bit 0 is the edge input; in button mode 01 = up, 10 = down, 00 = idle, 11 = down |
| sleep_i | input | 1 | Shutdown: clears the code and freezes the timers |
| pwm_o | output | 1 | PWM output |
| code_o | output | 6 | Current level code |

## Verification
Edge mode is driven with groups of edges of different sizes: 1, 5, 57, 1 and 63. These show the difference between a plain increment, the wrap at full scale and the 63-edge decrement. Button mode is driven with several kinds of press:
- a bounce shorter than the debounce window;
- single presses in each direction, including the both-buttons code;
- a tick count that stops one tick short of a unit;
- a long hold, sampled one strobe before and one strobe on each expected repeat.

The long holds that run to each end show the difference between saturation and wrapping. A press that is interrupted by shutdown shows whether the debounce state was frozen or reset.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [1:0] {
    PRESS_NONE = 2'd0,
    PRESS_UP   = 2'd1,
    PRESS_DN   = 2'd2
  } press_e;

  // Pin code to press state; both buttons at once resolve to down.
  function automatic press_e pin_to_press(input logic [1:0] pin);
    case (pin)
      2'b01:   return PRESS_UP;
      2'b10:   return PRESS_DN;
      2'b11:   return PRESS_DN;
      default: return PRESS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/plc_unit_div.sv
module plc_unit_div #(
  parameter int UNIT_TICKS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic freeze_i,
  output logic stb_o
);
  localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = tick_i && !freeze_i;
  assign stb_o  = cnt_en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R8: a strobe is only ever produced on a tick
  p_stb_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (tick_i && !freeze_i));

endmodule

// File: rtl/plc_button.sv
module plc_button
  import plc_pkg::*;
#(
  parameter int DEB_UNITS  = 1,
  parameter int HOLD_UNITS = 32,
  parameter int REP_UNITS  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       freeze_i,
  input  logic [1:0] pin_i,
  input  logic       unit_stb_i,
  output logic       up_step_o,
  output logic       dn_step_o
);
  localparam int SW   = $clog2(DEB_UNITS + 1);
  localparam int MAXU = (HOLD_UNITS > REP_UNITS) ? HOLD_UNITS : REP_UNITS;
  localparam int RW   = $clog2(MAXU + 1);
  localparam logic [SW-1:0] DEB_L  = SW'(DEB_UNITS);
  localparam logic [RW-1:0] HOLD_L = RW'(HOLD_UNITS);
  localparam logic [RW-1:0] REP_L  = RW'(REP_UNITS);

  press_e        now_s;
  press_e        cand_q, cand_d;
  press_e        deb_q, deb_d;
  logic [SW-1:0] stab_q, stab_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          rep_q, rep_d;
  logic          accept;
  logic          up_d, dn_d;

  assign now_s = pin_to_press(pin_i);

  // Debounce, hold and repeat next state
  always_comb begin
    cand_d = cand_q;
    deb_d  = deb_q;
    stab_d = stab_q;
    rc_d   = rc_q;
    rep_d  = rep_q;
    accept = 1'b0;
    up_d   = 1'b0;
    dn_d   = 1'b0;
    if (!enable_i) begin
      cand_d = PRESS_NONE;
      deb_d  = PRESS_NONE;
      stab_d = '0;
      rc_d   = '0;
      rep_d  = 1'b0;
    end else if (!freeze_i) begin
      if (now_s != cand_q) begin
        cand_d = now_s;
        stab_d = '0;
      end else if (unit_stb_i && (stab_q < DEB_L)) begin
        stab_d = stab_q + 1'b1;
        if ((stab_q == DEB_L - 1'b1) && (cand_q != deb_q)) begin
          deb_d  = cand_q;
          accept = 1'b1;
        end
      end

      if (accept) begin
        rc_d  = '0;
        rep_d = 1'b0;
        up_d  = (cand_q == PRESS_UP);
        dn_d  = (cand_q == PRESS_DN);
      end else if (unit_stb_i && (deb_q != PRESS_NONE)) begin
        if (!rep_q && (rc_q == HOLD_L - 1'b1)) begin
          rc_d  = '0;
          rep_d = 1'b1;
          up_d  = (deb_q == PRESS_UP);
          dn_d  = (deb_q == PRESS_DN);
        end else if (rep_q && (rc_q == REP_L - 1'b1)) begin
          rc_d = '0;
          up_d = (deb_q == PRESS_UP);
          dn_d = (deb_q == PRESS_DN);
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= PRESS_NONE;
      deb_q  <= PRESS_NONE;
      stab_q <= '0;
      rc_q   <= '0;
      rep_q  <= 1'b0;
    end else begin
      cand_q <= cand_d;
      deb_q  <= deb_d;
      stab_q <= stab_d;
      rc_q   <= rc_d;
      rep_q  <= rep_d;
    end
  end

  assign up_step_o = up_d;
  assign dn_step_o = dn_d;

  // R8: steps only on a unit strobe
  p_step_on_stb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_step_o || dn_step_o) |-> unit_stb_i);

  // R10: frozen state does not move while in shutdown
  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && enable_i) |=> ($stable(stab_q) && $stable(rc_q) && $stable(deb_q)));

  // R11: an idle debounced state never produces a step
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_q == PRESS_NONE && cand_q == PRESS_NONE) |-> !(up_step_o || dn_step_o));

endmodule

// File: rtl/plc_level.sv
module plc_level #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sleep_i,
  input  logic              inc_i,
  input  logic              up_step_i,
  input  logic              dn_step_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (sleep_i) begin
      code_d = '0;
    end else if (!mode_i) begin
      if (inc_i) code_d = code_q + 1'b1;
    end else if (up_step_i && (code_q != '1)) begin
      code_d = code_q + 1'b1;
    end else if (dn_step_i && (code_q != '0)) begin
      code_d = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  // R2: edge mode wraps at full scale
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !sleep_i && inc_i && code_q == '1) |=> (code_q == '0));
  // R4: holds at full scale
  p_sat_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sleep_i && !dn_step_i && code_q == '1) |=> (code_q == '1));
  // R5: holds at zero scale
  p_sat_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sleep_i && !up_step_i && code_q == '0) |=> (code_q == '0));
  // R10: shutdown clears the code
  p_sleep_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (code_q == '0));

endmodule

// File: rtl/plc_pwm.sv
module plc_pwm #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sleep_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pwm_o
);
  logic [CODE_W-1:0] slot_q, slot_d;
  logic              pwm_q, pwm_d;

  always_comb begin
    slot_d = slot_q;
    if (sleep_i)   slot_d = '0;
    else if (en_i) slot_d = slot_q + 1'b1;
    pwm_d = !sleep_i && (slot_q < code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R9: zero code never raises the output
  p_zero_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> !pwm_q);
  // R10: shutdown holds the output low
  p_sleep_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !pwm_q);

endmodule

// File: rtl/pwm_level_channel.sv
module pwm_level_channel #(
  parameter int CODE_W     = 6,
  parameter int UNIT_TICKS = 128,
  parameter int DEB_UNITS  = 1,
  parameter int HOLD_UNITS = 32,
  parameter int REP_UNITS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwm_en_i,
  input  logic              mode_i,
  input  logic [1:0]        pin_i,
  input  logic              sleep_i,
  output logic              pwm_o,
  output logic [CODE_W-1:0] code_o
);
  logic       rst_s1_q, rst_n;
  logic       pin0_q;
  logic       inc_edge;
  logic       unit_stb;
  logic       up_step, dn_step;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pin0_q <= 1'b0;
    else        pin0_q <= pin_i[0];
  end

  assign inc_edge = pin_i[0] && !pin0_q;

  plc_unit_div #(.UNIT_TICKS(UNIT_TICKS)) u_div (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i),
    .freeze_i(sleep_i), .stb_o(unit_stb)
  );

  plc_button #(
    .DEB_UNITS(DEB_UNITS), .HOLD_UNITS(HOLD_UNITS), .REP_UNITS(REP_UNITS)
  ) u_btn (
    .clk_i(clk_i), .rst_ni(rst_n), .enable_i(mode_i), .freeze_i(sleep_i),
    .pin_i(pin_i), .unit_stb_i(unit_stb),
    .up_step_o(up_step), .dn_step_o(dn_step)
  );

  plc_level #(.CODE_W(CODE_W)) u_level (
    .clk_i(clk_i), .rst_ni(rst_n), .mode_i(mode_i), .sleep_i(sleep_i),
    .inc_i(inc_edge), .up_step_i(up_step), .dn_step_i(dn_step),
    .code_o(code_o)
  );

  plc_pwm #(.CODE_W(CODE_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(pwm_en_i), .sleep_i(sleep_i),
    .code_i(code_o), .pwm_o(pwm_o)
  );

  // R1: outputs idle while reset is held
  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_n |-> (code_o == '0 && !pwm_o));

endmodule

// File: tb/sim_pwm_level_channel.sv
module sim_pwm_level_channel;
  localparam int UT = 3;
  localparam int DB = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       pwm_en_i = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] pin_i = 2'b00;
  logic       sleep_i = 1'b0;
  logic       pwm_o;
  logic [5:0] code_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  pwm_level_channel #(.UNIT_TICKS(UT), .DEB_UNITS(DB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pwm_en_i(pwm_en_i),
    .mode_i(mode_i), .pin_i(pin_i), .sleep_i(sleep_i),
    .pwm_o(pwm_o), .code_o(code_o)
  );

  // Edge-mode vectors: {edges to send, expected code}
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{1, 1}, '{5, 6}, '{57, 63}, '{1, 0}, '{63, 63}, '{2, 1}};

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      pin_i = 2'b01; @(negedge clk);
      pin_i = 2'b00; @(negedge clk);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic units(input int n);
    ticks(n * UT);
  endtask

  task automatic duty(input int exp, input string req);
    int hi = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    check(hi, exp, req);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(code_o, 0, "R1 code in reset");
    check(pwm_o, 0, "R1 pwm in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check(code_o, 0, "R1 code after reset");

    // R2: edge mode table
    for (int v = 0; v < NV; v++) begin
      edges(VEC[v][0]);
      check(code_o, VEC[v][1], "R2 edge count/wrap");
    end
    edges(5);
    check(code_o, 6, "R2 edge count");
    duty(6, "R9 duty at 6");

    // Button mode
    mode_i = 1'b1;
    do_reset();
    pin_i = 2'b10; units(DB);
    check(code_o, 0, "R5 down at zero holds");
    pin_i = 2'b00; units(DB);

    // R6: bounce shorter than the debounce window
    pin_i = 2'b01; units(DB - 1);
    pin_i = 2'b00; units(DB + 1);
    check(code_o, 0, "R6 short press rejected");

    // R7: hold and repeat spacing
    pin_i = 2'b01; units(DB);
    check(code_o, 1, "R4 up press");
    units(31); check(code_o, 1, "R7 before hold delay");
    units(1);  check(code_o, 2, "R7 first repeat");
    units(3);  check(code_o, 2, "R7 before repeat");
    units(1);  check(code_o, 3, "R7 second repeat");
    units(4);  check(code_o, 4, "R7 third repeat");
    pin_i = 2'b00; units(DB);
    units(6);  check(code_o, 4, "R11 no step after release");

    // R3: both buttons act as down, then plain down
    pin_i = 2'b11; units(DB);
    check(code_o, 3, "R3 both = down");
    pin_i = 2'b00; units(DB);
    pin_i = 2'b10; units(DB);
    check(code_o, 2, "R3 down code");
    pin_i = 2'b00; units(DB);

    // R8: one tick short of a unit gives no strobe
    pin_i = 2'b01; units(1); ticks(UT - 1);
    check(code_o, 2, "R8 partial unit");
    ticks(1);
    check(code_o, 3, "R8 unit completes");
    pin_i = 2'b00; units(DB);

    // R4: saturate at full scale
    pin_i = 2'b01; units(274);
    check(code_o, 63, "R4 saturate high");
    pin_i = 2'b00; units(DB);
    check(code_o, 63, "R4 hold high");
    duty(63, "R9 duty at 63");

    // R5: saturate at zero
    pin_i = 2'b10; units(290);
    check(code_o, 0, "R5 saturate low");
    pin_i = 2'b00; units(DB);
    duty(0, "R9 duty at 0");

    // R10: shutdown clears and freezes
    pin_i = 2'b01; units(DB);
    pin_i = 2'b00; units(DB);
    check(code_o, 1, "R10 setup");
    pin_i = 2'b01; units(1);
    sleep_i = 1'b1; @(negedge clk);
    check(code_o, 0, "R10 code cleared");
    units(5);
    check(code_o, 0, "R10 press ignored");
    duty(0, "R10 pwm low");
    sleep_i = 1'b0; repeat (3) @(negedge clk);
    check(code_o, 0, "R10 no step on exit");
    units(1);
    check(code_o, 1, "R10 frozen debounce resumes");
    pin_i = 2'b00;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule